// File: doc/BRIEF.md
# Block/Frame Sync Protection Controller

This block decides when a packetized broadcast bitstream is aligned at block level and at frame level. An external correlator compares the most recent received bits with the expected block identifier word. For every received bit it hands over a strobe, the number of mismatching identifier bits, and a flag that says the identifier matched is the frame-opening variant. The controller runs a flywheel. It looks for an identifier, expects the next one exactly one block length later, and declares block lock only after a programmable run of good identifiers at that spacing. Once locked, it drops lock only after a programmable run of failed checks at the expected positions.

Frame alignment is tracked on top of block alignment in the same way. It counts block-start events and expects the frame-opening identifier once per frame length. Acquisition and loss each have their own protection count, stored as the effective count minus one. The identifier check uses two mismatch tolerances, a wider one while hunting and a separate one while locked. Three 8-bit configuration words hold all of these values. A synchronous reset restores the defaults.

The block outputs two lock levels and two one-cycle start strobes. All four are registered, so they change in the clock cycle after the bit strobe that caused the change.

Top module: `sync_protect_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `blk_lock`, `frm_lock`, `blk_start` and `frm_start` are 0. The configuration then holds these defaults:
  - tolerances: lock-keeping 2, hunting 2;
  - block protection: loss field 1, acquire field 7;
  - frame protection: loss field 1, acquire field 7.
- R2: A write with `cfg_we`=1 stores `cfg_data` into the word chosen by `cfg_addr`. In every word, bits [7:4] are the loss-side field and bits [3:0] are the acquire-side field.
  - Address 0 holds the mismatch tolerances.
  - Address 1 holds the block protection fields.
  - Address 2 holds the frame protection fields.
  - Address 3 is ignored.
  - A protection field of value n means an effective count of n+1.
- R3: While block lock is not held, the first bit strobe whose mismatch count is within the hunting tolerance arms the search. Lock is declared when the acquire count of consecutive passing identifiers has been seen, spaced exactly BLOCK_BITS strobes apart. An identifier that fails at the expected position disarms the search, and the counting starts again.
- R4: While the search is armed, passing identifiers at positions other than the expected one are ignored.
- R5: While block lock is held, the controller checks only at the expected positions. A failed check counts a miss, and a passing check clears the miss count. Lock is dropped at the check that completes the loss count of consecutive misses.
- R6: Both tolerance checks are inclusive: a mismatch count equal to the tolerance passes, and one greater fails. The hunting tolerance applies to acquisition and the lock-keeping tolerance applies to loss checks, independently.
- R7: `blk_start` is a one-cycle pulse in the cycle after the bit strobe that completes an identifier at an expected position. It fires whenever block lock is held after that strobe, which includes the acquiring identifier. It does not fire at the check that drops lock.
- R8: Frame acquisition and loss follow the rules of R3 and R5, with three differences. The events counted are block-start events. A pass is `frm_mark`=1 on that event. The spacing is FRAME_BLOCKS blocks, and the counts come from the frame protection word.
- R9: `frm_lock` is never high while `blk_lock` is low. Frame candidates seen while block lock is not held are ignored. When block lock is lost, frame lock falls in the same cycle and frame acquisition restarts from nothing.
- R10: `frm_start` is a one-cycle pulse that coincides with `blk_start`. It fires at block-start events that fall on the expected frame position (or acquire frame lock) while frame lock is held afterwards.
- R11: A synchronous reset reloads the default configuration, even after earlier writes have changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration word select (0 tolerance, 1 block, 2 frame, 3 ignored) |
| cfg_data | input | 8 | Configuration word: [7:4] loss side, [3:0] acquire side |
| bit_stb | input | 1 | One pulse per received bit; qualifies the next two inputs |
| id_mism | input | MISM_W | Mismatching identifier bits for the window ending at this bit |
| frm_mark | input | 1 | Identifier at this bit is the frame-opening variant |
| blk_lock | output | 1 | High while block synchronization is held |
| frm_lock | output | 1 | High while frame synchronization is held |
| blk_start | output | 1 | One-cycle strobe after each accepted block identifier |
| frm_start | output | 1 | One-cycle strobe at each frame opening while frame lock is held |

## Verification
The bench builds the controller with BLOCK_BITS=6, FRAME_BLOCKS=3 and MISM_W=5. With these values a whole block takes six strobes and a frame takes three blocks. That makes it cheap to sweep every block acquire/loss field pair from 0 to 3, every frame pair from 0 to 2, and tolerances 0 to 4, each at and one above the boundary. The short spacings also bring within reach the position-dependent cases: a stray passing identifier inside an armed search, the recovery of a miss run by one good check, frame hunting during block hunting, and block loss collapsing frame lock.

// File: rtl/sync_prot_pkg.sv
package sync_prot_pkg;

    // Width of every programmable count or tolerance field
    localparam int FIELD_W = 4;

    typedef logic [FIELD_W-1:0] cnt_t;

    // One 8-bit configuration word: loss side in the upper nibble
    typedef struct packed {
        cnt_t back;
        cnt_t fwd;
    } pair_t;

    // Complete configuration image
    typedef struct packed {
        pair_t tol;
        pair_t blk;
        pair_t frm;
    } sync_cfg_t;

    typedef enum logic [1:0] {
        CA_TOL  = 2'd0,
        CA_BLK  = 2'd1,
        CA_FRM  = 2'd2,
        CA_NONE = 2'd3
    } cfg_addr_e;

    typedef enum logic [1:0] {
        G_IDLE   = 2'd0,
        G_ARMED  = 2'd1,
        G_LOCKED = 2'd2
    } guard_st_e;

    localparam pair_t TOL_DFLT  = '{back: 4'd2, fwd: 4'd2};
    localparam pair_t PROT_DFLT = '{back: 4'd1, fwd: 4'd7};
    localparam sync_cfg_t CFG_DFLT = '{tol: TOL_DFLT, blk: PROT_DFLT, frm: PROT_DFLT};

    function automatic pair_t to_pair(input logic [7:0] d);
        return pair_t'(d);
    endfunction

endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
    import sync_prot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [7:0]  data,
    output sync_cfg_t   cfg
);

    sync_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_DFLT;
        end else if (we) begin
            case (cfg_addr_e'(addr))
                CA_TOL:  cfg_q.tol <= to_pair(data);
                CA_BLK:  cfg_q.blk <= to_pair(data);
                CA_FRM:  cfg_q.frm <= to_pair(data);
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R11
    dflt_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == CFG_DFLT));

endmodule

// File: rtl/sync_id_judge.sv
module sync_id_judge
    import sync_prot_pkg::*;
#(
    parameter int MISM_W = 5
) (
    input  logic [MISM_W-1:0] mism,
    input  pair_t             tol,
    output logic              pass_fwd,
    output logic              pass_back
);

    // Common comparison width so any mismatch width lines up with the fields
    localparam int CW = (MISM_W > FIELD_W) ? MISM_W : FIELD_W;

    logic [CW-1:0] m_ext;
    logic [CW-1:0] tf_ext;
    logic [CW-1:0] tb_ext;

    assign m_ext  = CW'(mism);
    assign tf_ext = CW'(tol.fwd);
    assign tb_ext = CW'(tol.back);

    // Inclusive tolerances: equal passes
    assign pass_fwd  = (m_ext <= tf_ext);
    assign pass_back = (m_ext <= tb_ext);

endmodule

// File: rtl/sync_guard.sv
module sync_guard
    import sync_prot_pkg::*;
#(
    parameter int PERIOD = 288
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,        // force to idle this cycle
    input  logic tick,       // one unit of spacing (bit or block)
    input  logic pass_fwd,   // candidate quality while hunting
    input  logic pass_back,  // candidate quality while locked
    input  cnt_t fwd_n,      // acquire count minus one
    input  cnt_t back_n,     // loss count minus one
    output logic locked,
    output logic lock_nxt,
    output logic mark        // accepted expected position, lock held after it
);

    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    guard_st_e     st_q, st_d;
    logic [PW-1:0] pos_q, pos_d;
    cnt_t          hit_q, hit_d;
    cnt_t          miss_q, miss_d;
    logic          at_last;

    assign at_last = (pos_q == LAST);

    always_comb begin
        st_d   = st_q;
        pos_d  = pos_q;
        hit_d  = hit_q;
        miss_d = miss_q;
        mark   = 1'b0;
        if (tick) begin
            pos_d = at_last ? '0 : pos_q + 1'b1;
            case (st_q)
                G_IDLE: begin
                    if (pass_fwd) begin
                        // first candidate defines the flywheel phase
                        pos_d = '0;
                        if (fwd_n == '0) begin
                            st_d   = G_LOCKED;
                            miss_d = '0;
                            mark   = 1'b1;
                        end else begin
                            st_d  = G_ARMED;
                            hit_d = cnt_t'(1);
                        end
                    end
                end
                G_ARMED: begin
                    if (at_last) begin
                        if (!pass_fwd) begin
                            st_d  = G_IDLE;
                            hit_d = '0;
                        end else if (hit_q == fwd_n) begin
                            st_d   = G_LOCKED;
                            miss_d = '0;
                            mark   = 1'b1;
                        end else begin
                            hit_d = hit_q + 1'b1;
                        end
                    end
                end
                G_LOCKED: begin
                    if (at_last) begin
                        if (pass_back) begin
                            miss_d = '0;
                            mark   = 1'b1;
                        end else if (miss_q == back_n) begin
                            st_d   = G_IDLE;
                            hit_d  = '0;
                            miss_d = '0;
                        end else begin
                            miss_d = miss_q + 1'b1;
                            mark   = 1'b1;
                        end
                    end
                end
                default: begin
                    st_d = G_IDLE;
                end
            endcase
        end
        if (clr) begin
            st_d   = G_IDLE;
            hit_d  = '0;
            miss_d = '0;
            mark   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= G_IDLE;
            pos_q  <= '0;
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            pos_q  <= pos_d;
            hit_q  <= hit_d;
            miss_q <= miss_d;
        end
    end

    assign locked   = (st_q == G_LOCKED);
    assign lock_nxt = (st_d == G_LOCKED);

    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(tick));

    // R5
    fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(tick) || $past(clr) || $past(rst)));

endmodule

// File: rtl/sync_protect_ctrl.sv
module sync_protect_ctrl
    import sync_prot_pkg::*;
#(
    parameter int BLOCK_BITS   = 288,
    parameter int FRAME_BLOCKS = 272,
    parameter int MISM_W       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_data,
    input  logic              bit_stb,
    input  logic [MISM_W-1:0] id_mism,
    input  logic              frm_mark,
    output logic              blk_lock,
    output logic              frm_lock,
    output logic              blk_start,
    output logic              frm_start
);

    sync_cfg_t cfg;
    logic      pass_fwd, pass_back;
    logic      blk_lock_nxt, blk_mark;
    logic      frm_lock_nxt, frm_mark_acc;
    logic      blk_start_q, frm_start_q;

    sync_cfg_regs u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .data (cfg_data),
        .cfg  (cfg)
    );

    sync_id_judge #(.MISM_W(MISM_W)) u_judge (
        .mism      (id_mism),
        .tol       (cfg.tol),
        .pass_fwd  (pass_fwd),
        .pass_back (pass_back)
    );

    // Block level: spacing counted in bit strobes
    sync_guard #(.PERIOD(BLOCK_BITS)) u_blk (
        .clk       (clk),
        .rst       (rst),
        .clr       (1'b0),
        .tick      (bit_stb),
        .pass_fwd  (pass_fwd),
        .pass_back (pass_back),
        .fwd_n     (cfg.blk.fwd),
        .back_n    (cfg.blk.back),
        .locked    (blk_lock),
        .lock_nxt  (blk_lock_nxt),
        .mark      (blk_mark)
    );

    // Frame level: spacing counted in accepted block starts,
    // held idle whenever block lock will not be held
    sync_guard #(.PERIOD(FRAME_BLOCKS)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .clr       (!blk_lock_nxt),
        .tick      (blk_mark),
        .pass_fwd  (frm_mark),
        .pass_back (frm_mark),
        .fwd_n     (cfg.frm.fwd),
        .back_n    (cfg.frm.back),
        .locked    (frm_lock),
        .lock_nxt  (frm_lock_nxt),
        .mark      (frm_mark_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_start_q <= 1'b0;
            frm_start_q <= 1'b0;
        end else begin
            blk_start_q <= blk_mark;
            frm_start_q <= frm_mark_acc;
        end
    end

    assign blk_start = blk_start_q;
    assign frm_start = frm_start_q;

    // R9
    frm_needs_blk_chk: assert property (@(posedge clk) disable iff (rst)
        frm_lock |-> blk_lock);

    // R9
    frm_nxt_needs_blk_chk: assert property (@(posedge clk) disable iff (rst)
        frm_lock_nxt |-> blk_lock_nxt);

    // R7
    bs_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> blk_lock);

    // R10
    fs_with_bs_chk: assert property (@(posedge clk) disable iff (rst)
        frm_start |-> (blk_start && frm_lock));

endmodule

// File: tb/sync_protect_ctrl_bench.sv
`timescale 1ns/1ps
module sync_protect_ctrl_bench;

    localparam int BB = 6;
    localparam int FB = 3;
    localparam int MW = 5;
    localparam int FILL = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [7:0]    cfg_data = '0;
    logic          bit_stb = 1'b0;
    logic [MW-1:0] id_mism = '0;
    logic          frm_mark = 1'b0;
    logic          blk_lock, frm_lock, blk_start, frm_start;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int o_bl, o_fl, o_bs, o_fs;

    always #2 clk = ~clk;

    sync_protect_ctrl #(.BLOCK_BITS(BB), .FRAME_BLOCKS(FB), .MISM_W(MW)) u_sync_protect_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .bit_stb(bit_stb), .id_mism(id_mism), .frm_mark(frm_mark),
        .blk_lock(blk_lock), .frm_lock(frm_lock), .blk_start(blk_start), .frm_start(frm_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic do_reset();
        rst = 1'b1;
        bit_stb = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        cfg_we = 1'b1;
        cfg_addr = 2'(addr);
        cfg_data = 8'(data);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bitx(input int m, input int fm);
        bit_stb = 1'b1;
        id_mism = MW'(m);
        frm_mark = fm[0];
        @(posedge clk);
        @(negedge clk);
        bit_stb = 1'b0;
        frm_mark = 1'b0;
        o_bl = int'(blk_lock);
        o_fl = int'(frm_lock);
        o_bs = int'(blk_start);
        o_fs = int'(frm_start);
    endtask

    // one block: fillers, then the identifier at the block's last bit
    task automatic blk(input int m, input int fm);
        for (int i = 0; i < BB - 1; i++) bitx(FILL, 0);
        bitx(m, fm);
    endtask

    task automatic default_run(input string tag);
        for (int k = 1; k <= 8; k++) begin
            blk(2, 0);
            chk({tag, " acquire after 8 (default)"}, o_bl, (k == 8) ? 1 : 0);
        end
        blk(3, 0);
        chk({tag, " first default miss keeps lock"}, o_bl, 1);
        blk(3, 0);
        chk({tag, " second default miss drops lock"}, o_bl, 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 blk_lock after reset", int'(blk_lock), 0);
        chk("R1 frm_lock after reset", int'(frm_lock), 0);
        chk("R1 blk_start after reset", int'(blk_start), 0);
        chk("R1 frm_start after reset", int'(frm_start), 0);
        default_run("R1");

        // R11 and R2: programmed values replaced by defaults; address 3 ignored
        wr(1, 8'h00);
        wr(0, 8'h00);
        do_reset();
        wr(3, 8'h00);
        default_run("R11/R2");

        // R3 R5 R7 sweep of block protection fields
        for (int f = 0; f < 4; f++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset();
                wr(1, b * 16 + f);
                for (int k = 1; k <= f + 1; k++) begin
                    blk(0, 0);
                    chk("R3 block acquire count", o_bl, (k == f + 1) ? 1 : 0);
                    chk("R7 start on acquire", o_bs, (k == f + 1) ? 1 : 0);
                end
                for (int j = 1; j <= b + 1; j++) begin
                    blk(3, 0);
                    chk("R5 block loss count", o_bl, (j <= b) ? 1 : 0);
                    chk("R7 start while held", o_bs, (j <= b) ? 1 : 0);
                end
            end
        end

        // R3 a failed expected identifier disarms the search
        do_reset();
        wr(1, 8'h02);
        blk(0, 0);
        blk(9, 0);
        blk(0, 0);
        blk(0, 0);
        chk("R3 restart after failed check", o_bl, 0);
        blk(0, 0);
        chk("R3 lock after fresh run of 3", o_bl, 1);

        // R4 stray passing identifier while armed
        do_reset();
        wr(1, 8'h01);
        blk(0, 0);
        bitx(FILL, 0);
        bitx(0, 0);
        chk("R4 stray does not lock", o_bl, 0);
        bitx(FILL, 0);
        bitx(FILL, 0);
        bitx(FILL, 0);
        bitx(0, 0);
        chk("R4 lock at original spacing", o_bl, 1);
        chk("R7 filler bits give no start", o_bs, 1);

        // R5 a passing check clears the miss run
        do_reset();
        wr(1, 8'h10);
        blk(0, 0);
        blk(3, 0);
        blk(0, 0);
        blk(3, 0);
        chk("R5 miss run cleared by pass", o_bl, 1);
        blk(3, 0);
        chk("R5 two consecutive misses drop", o_bl, 0);

        // R6 inclusive tolerances, sweep
        for (int t = 0; t < 5; t++) begin
            do_reset();
            wr(0, t * 16 + t);
            wr(1, 8'h00);
            blk(t + 1, 0);
            chk("R6 hunt rejects tol+1", o_bl, 0);
            blk(t, 0);
            chk("R6 hunt accepts tol", o_bl, 1);
            blk(t, 0);
            chk("R6 lock keeps at tol", o_bl, 1);
            blk(t + 1, 0);
            chk("R6 lock drops at tol+1", o_bl, 0);
        end

        // R6 separate hunting and lock-keeping tolerances
        do_reset();
        wr(0, 8'h15);
        wr(1, 8'h00);
        blk(5, 0);
        chk("R6 hunting tolerance 5", o_bl, 1);
        blk(2, 0);
        chk("R6 lock-keeping tolerance 1", o_bl, 0);

        // R8 R10 frame sweep
        for (int f = 0; f < 3; f++) begin
            for (int b = 0; b < 3; b++) begin
                do_reset();
                wr(1, 8'h00);
                wr(2, b * 16 + f);
                blk(0, 0);
                chk("R8 no frame lock without mark", o_fl, 0);
                for (int k = 1; k <= f + 1; k++) begin
                    if (k > 1) begin
                        for (int i = 0; i < FB - 1; i++) begin
                            blk(0, 0);
                            chk("R10 no frame start between", o_fs, 0);
                        end
                    end
                    blk(0, 1);
                    chk("R8 frame acquire count", o_fl, (k == f + 1) ? 1 : 0);
                    chk("R10 frame start on acquire", o_fs, (k == f + 1) ? 1 : 0);
                end
                for (int j = 1; j <= b + 1; j++) begin
                    for (int i = 0; i < FB - 1; i++) blk(0, 0);
                    blk(0, 0);
                    chk("R8 frame loss count", o_fl, (j <= b) ? 1 : 0);
                    chk("R10 frame start while held", o_fs, (j <= b) ? 1 : 0);
                end
            end
        end

        // R9 frame marks during block hunt are ignored
        do_reset();
        wr(2, 8'h00);
        for (int k = 0; k < 3; k++) begin
            blk(0, 1);
            chk("R9 no frame lock while block hunts", o_fl, 0);
        end

        // R9 block loss drops frame lock in the same cycle
        do_reset();
        wr(1, 8'h00);
        wr(2, 8'h00);
        blk(0, 1);
        chk("R9 frame locked with block", o_fl, 1);
        blk(9, 0);
        chk("R9 block dropped", o_bl, 0);
        chk("R9 frame dropped same cycle", o_fl, 0);
        blk(0, 0);
        chk("R9 frame restarts from nothing", o_fl, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule